// File: doc/BRIEF.md
# Multi-Register Stack Pop Sequencer

This block restores a set of processor registers from a stack frame in memory and then releases the frame. A 5-bit select mask chooses up to four single registers and an optional block of seven loop and control registers. The block issues one 32-bit read at a time, from the highest frame offset down to the lowest. It writes each returned word into the register file in the same cycle the word arrives. After the last write, it commits the new stack pointer in the cycle that it pulses `done_o`.

The frame layout is fixed and does not depend on the order in which the registers were written. When the control block is selected, it occupies the low 32 bytes of the frame. That 32-byte area includes one padding word at the frame base, which is never read. The selected single registers are packed above the control block with no gaps. The first register in canonical order sits at the highest address.

Top module: `stack_pop_seq`

## Requirements
- R1: After a cycle with `rst_n` low, `busy_o`, `done_o`, `rd_req_o`, `rf_we_o` and `sp_wr_en_o` are all 0.
- R2: Mask bit 0 selects D2, bit 1 selects D3, bit 2 selects A2, bit 3 selects A3, and bit 4 selects the control block. Register indices on `rf_idx_o` are: D0=0, D1=1, D2=2, D3=3, A0=4, A1=5, A2=6, A3=7, MDR=8, LIR=9, LAR=10.
- R3: Selected single registers are restored in the order D2, D3, A2, A3, skipping unselected ones. With n of them and no control block, the k-th one (k from 0) is read from SP+4*(n-1-k).
- R4: The control block is read as D0@SP+28, D1@SP+24, A0@SP+20, A1@SP+16, MDR@SP+12, LIR@SP+8 and LAR@SP+4. SP+0 is never read.
- R5: When the control block and n single registers are both selected, the singles are read first, from SP+32+4*(n-1-k), followed by the control block.
- R6: `sp_wr_en_o` is high for one cycle, together with `done_o`, the cycle after the last register write. `sp_wr_data_o` equals SP + 4*n + 32*(control selected).
- R7: `rd_req_o` stays high with a constant `rd_addr_o` until `rsp_valid_i`. The register write (`rf_we_o`, `rf_idx_o`, `rf_data_o` = `rsp_data_i`) occurs in that response cycle.
- R8: An all-zero mask raises `done_o` in the cycle after start, with no reads, no register writes and no SP write.
- R9: `start_i` has no effect while `busy_o` is high. The operation in progress completes with its original mask and SP.
- R10: `done_o` lasts exactly one cycle, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| mask_i | input | 5 | Register select mask |
| sp_i | input | 32 | Stack pointer at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Read byte address |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 32 | Read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_idx_o | output | 4 | Register index |
| rf_data_o | output | 32 | Register write data |
| sp_wr_en_o | output | 1 | Stack pointer write enable |
| sp_wr_data_o | output | 32 | New stack pointer value |

## Verification
The assertions assume that the frame does not wrap past the top of the address space, so that read addresses strictly fall from one read to the next. They also assume that `rsp_valid_i` is raised only while a read is pending. The stimulus keeps SP word-aligned and below 0x7FFF_FFC0. Its memory model answers only an open request, after a random delay of zero to two cycles. Random masks are mixed with directed ones: each single register, all four singles, the control block alone, the control block with one, two and four singles, the empty mask, and a start pulse injected mid-operation.

// File: rtl/stack_pop_pkg.sv
// Package: shared constants, register index codes and sequencer state type
// for the stack pop sequencer. Assumes 32-bit words and byte addressing.
package stack_pop_pkg;

    localparam int N_IND           = 4;   // individually selectable registers
    localparam int N_CTL           = 7;   // registers in the control block
    localparam int CTL_FRAME_SLOTS = 8;   // control block words incl. padding
    localparam int WORD_BYTES      = 4;
    localparam int MASK_W          = N_IND + 1;
    localparam int CTL_BIT         = N_IND;
    localparam int IDX_W           = 4;
    localparam int MAX_READS       = N_IND + N_CTL;
    localparam int SLOT_W          = $clog2(MAX_READS + 1);
    localparam int MAX_FRAME       = (N_IND + CTL_FRAME_SLOTS) * WORD_BYTES;
    localparam int OFF_W           = $clog2(MAX_FRAME + 1);
    localparam int CNT_W           = $clog2(N_IND + 1);

    typedef enum logic [IDX_W-1:0] {
        REG_D0  = 4'd0,
        REG_D1  = 4'd1,
        REG_D2  = 4'd2,
        REG_D3  = 4'd3,
        REG_A0  = 4'd4,
        REG_A1  = 4'd5,
        REG_A2  = 4'd6,
        REG_A3  = 4'd7,
        REG_MDR = 4'd8,
        REG_LIR = 4'd9,
        REG_LAR = 4'd10
    } reg_id_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_FINISH = 2'd2
    } pop_state_e;

    // Canonical restore order of the single registers.
    function automatic reg_id_e ind_reg(input int k);
        case (k)
            0:       return REG_D2;
            1:       return REG_D3;
            2:       return REG_A2;
            default: return REG_A3;
        endcase
    endfunction

    // Control block order, highest address first.
    function automatic reg_id_e ctl_reg(input int c);
        case (c)
            0:       return REG_D0;
            1:       return REG_D1;
            2:       return REG_A0;
            3:       return REG_A1;
            4:       return REG_MDR;
            5:       return REG_LIR;
            default: return REG_LAR;
        endcase
    endfunction

endpackage

// File: rtl/pop_frame_calc.sv
// Frame size calculator: from a select mask, derives the number of single
// registers, the number of reads and the frame size in bytes.
// Purely combinational; assumes the mask layout of stack_pop_pkg.
module pop_frame_calc
    import stack_pop_pkg::*;
(
    input  logic [MASK_W-1:0] mask_i,
    output logic [CNT_W-1:0]  n_ind_o,
    output logic [SLOT_W-1:0] reads_o,
    output logic [OFF_W-1:0]  frame_bytes_o
);

    int n_ind_i;
    int slots_i;

    // Count the selected singles and size the frame.
    always_comb begin
        n_ind_i = $countones(mask_i[N_IND-1:0]);
        slots_i = n_ind_i + (mask_i[CTL_BIT] ? CTL_FRAME_SLOTS : 0);
        n_ind_o       = CNT_W'(n_ind_i);
        reads_o       = SLOT_W'(n_ind_i + (mask_i[CTL_BIT] ? N_CTL : 0));
        frame_bytes_o = OFF_W'(slots_i * WORD_BYTES);
    end

endmodule

// File: rtl/pop_slot_map.sv
// Slot mapper: for read slot number `slot_i` of the operation selected by
// `mask_i`, gives the destination register and its byte offset from SP.
// Single registers come first (highest addresses), then the control block.
// Assumes slot_i is below the read count of the mask.
module pop_slot_map
    import stack_pop_pkg::*;
(
    input  logic [MASK_W-1:0] mask_i,
    input  logic [CNT_W-1:0]  n_ind_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [IDX_W-1:0]  reg_o,
    output logic [OFF_W-1:0]  off_o
);

    // rank[g]: number of selected singles ahead of single g in canonical order
    logic [N_IND-1:0][CNT_W-1:0] rank;

    for (genvar g = 0; g < N_IND; g++) begin : g_rank
        if (g == 0) begin : g_first
            assign rank[g] = '0;
        end else begin : g_rest
            assign rank[g] = CNT_W'($countones(mask_i[g-1:0]));
        end
    end

    int base_i;
    int slot_int;
    int nind_int;
    int ctl_pos;

    // Pick the register and offset for the current slot.
    always_comb begin
        base_i   = mask_i[CTL_BIT] ? CTL_FRAME_SLOTS * WORD_BYTES : 0;
        slot_int = int'(slot_i);
        nind_int = int'(n_ind_i);
        ctl_pos  = slot_int - nind_int;
        reg_o    = REG_D0;
        off_o    = '0;
        if (slot_int < nind_int) begin
            for (int k = 0; k < N_IND; k++) begin
                if (mask_i[k] && (int'(rank[k]) == slot_int)) begin
                    reg_o = ind_reg(k);
                end
            end
            off_o = OFF_W'(base_i + WORD_BYTES * (nind_int - 1 - slot_int));
        end else begin
            reg_o = ctl_reg(ctl_pos);
            off_o = OFF_W'((N_CTL - ctl_pos) * WORD_BYTES);
        end
    end

endmodule

// File: rtl/pop_seq_ctrl.sv
// Sequence controller: accepts a start while idle, steps through the read
// slots one response at a time and ends with a single finish cycle.
// Assumes rsp_valid_i is only raised while a read is pending.
module pop_seq_ctrl
    import stack_pop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [SLOT_W-1:0] reads_i,
    input  logic              rsp_valid_i,
    output logic [MASK_W-1:0] mask_q_o,
    output logic [ADDR_W-1:0] sp_q_o,
    output logic [SLOT_W-1:0] slot_q_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_req_o,
    output logic              rf_we_o,
    output logic              sp_wr_en_o
);

    pop_state_e        state_q;
    logic [MASK_W-1:0] mask_q;
    logic [ADDR_W-1:0] sp_q;
    logic [SLOT_W-1:0] slot_q;
    logic              last_slot;

    assign last_slot = ((slot_q + 1'b1) == reads_i);

    // State, latched operands and slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            sp_q    <= '0;
            slot_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mask_q  <= mask_i;
                        sp_q    <= sp_i;
                        slot_q  <= '0;
                        state_q <= (mask_i == '0) ? ST_FINISH : ST_READ;
                    end
                end
                ST_READ: begin
                    if (rsp_valid_i) begin
                        if (last_slot) begin
                            state_q <= ST_FINISH;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Output decode from the state.
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        rd_req_o   = (state_q == ST_READ);
        rf_we_o    = (state_q == ST_READ) && rsp_valid_i;
        done_o     = (state_q == ST_FINISH);
        sp_wr_en_o = (state_q == ST_FINISH) && (mask_q != '0);
        mask_q_o   = mask_q;
        sp_q_o     = sp_q;
        slot_q_o   = slot_q;
    end

    // R7: a pending read keeps its slot until answered
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rsp_valid_i) |=> (rd_req_o && $stable(slot_q)));

    // R9: operands cannot change while an operation runs
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(mask_q) && $stable(sp_q)));

    // R10: done is one cycle and is followed by idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R6: the SP commit follows the final register write
    assert_sp_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en_o |-> $past(rf_we_o));

endmodule

// File: rtl/stack_pop_seq.sv
// Top level of the stack pop sequencer. Latches the mask and SP on start,
// reads the frame from the highest offset down, writes each word to the
// register file on arrival and commits SP plus the frame size with done.
// Assumes a word-aligned SP and a frame that does not wrap the address space.
module stack_pop_seq
    import stack_pop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_idx_o,
    output logic [DATA_W-1:0] rf_data_o,
    output logic              sp_wr_en_o,
    output logic [ADDR_W-1:0] sp_wr_data_o
);

    logic [MASK_W-1:0] mask_q;
    logic [ADDR_W-1:0] sp_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  n_ind;
    logic [SLOT_W-1:0] reads;
    logic [OFF_W-1:0]  frame_bytes;
    logic [IDX_W-1:0]  slot_reg;
    logic [OFF_W-1:0]  slot_off;

    pop_frame_calc u_frame (
        .mask_i        (mask_q),
        .n_ind_o       (n_ind),
        .reads_o       (reads),
        .frame_bytes_o (frame_bytes)
    );

    pop_slot_map u_map (
        .mask_i  (mask_q),
        .n_ind_i (n_ind),
        .slot_i  (slot_q),
        .reg_o   (slot_reg),
        .off_o   (slot_off)
    );

    pop_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mask_i      (mask_i),
        .sp_i        (sp_i),
        .reads_i     (reads),
        .rsp_valid_i (rsp_valid_i),
        .mask_q_o    (mask_q),
        .sp_q_o      (sp_q),
        .slot_q_o    (slot_q),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rd_req_o    (rd_req_o),
        .rf_we_o     (rf_we_o),
        .sp_wr_en_o  (sp_wr_en_o)
    );

    // Address, write-back and new-SP datapath.
    always_comb begin
        rd_addr_o    = sp_q + ADDR_W'(slot_off);
        rf_idx_o     = slot_reg;
        rf_data_o    = rsp_data_i;
        sp_wr_data_o = sp_q + ADDR_W'(frame_bytes);
    end

    // R3/R5: successive reads move strictly downward
    assert_desc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> (!rd_req_o || (rd_addr_o < $past(rd_addr_o))));

    // R4: the padding word at the frame base is never read
    assert_pad_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && mask_q[CTL_BIT]) |-> ((rd_addr_o - sp_q) >= ADDR_W'(WORD_BYTES)));

    // R8: an empty mask finishes next cycle without an SP write
    assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (mask_i == '0)) |=> (done_o && !sp_wr_en_o && !rd_req_o));

    // R1: reset leaves the block idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !rd_req_o && !sp_wr_en_o));

endmodule

// File: tb/stack_pop_seq_tb_top.sv
module stack_pop_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  mask_i = '0;
    logic [31:0] sp_i = '0;
    logic        busy_o, done_o, rd_req_o, rf_we_o, sp_wr_en_o;
    logic [31:0] rd_addr_o, rf_data_o, sp_wr_data_o;
    logic        rsp_valid_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic [3:0]  rf_idx_o;

    always #5 clk = ~clk;

    stack_pop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i), .sp_i(sp_i),
        .busy_o(busy_o), .done_o(done_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rf_we_o(rf_we_o),
        .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o), .sp_wr_en_o(sp_wr_en_o),
        .sp_wr_data_o(sp_wr_data_o)
    );

    int tests = 0;
    int fails = 0;
    int exp_idx [11];
    int exp_off [11];
    int exp_n = 0;
    int exp_adv = 0;
    int wr_ptr = 0;
    int wait_cnt = 0;
    int cycles = 0;
    bit done_seen = 0;
    bit monitor_on = 0;
    logic [4:0]  op_mask = '0;
    logic [31:0] op_sp = '0;
    string op_tag = "R3";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
    endfunction

    // Expected frame from the requirements (R2..R6).
    task automatic build_exp(input logic [4:0] m);
        int singles [4];
        int ctl [7];
        int n;
        int base;
        singles = '{2, 3, 6, 7};
        ctl = '{0, 1, 4, 5, 8, 9, 10};
        n = 0;
        for (int k = 0; k < 4; k++) if (m[k]) n++;
        base = m[4] ? 32 : 0;
        exp_n = 0;
        for (int k = 0; k < 4; k++) begin
            if (m[k]) begin
                exp_idx[exp_n] = singles[k];
                exp_off[exp_n] = base + 4 * (n - 1 - exp_n);
                exp_n++;
            end
        end
        if (m[4]) begin
            for (int c = 0; c < 7; c++) begin
                exp_idx[exp_n] = ctl[c];
                exp_off[exp_n] = 28 - 4 * c;
                exp_n++;
            end
        end
        exp_adv = 4 * n + (m[4] ? 32 : 0);
    endtask

    // Memory responder and output monitor, both half a cycle from the edge.
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid_i = 1'b0;
            if (rd_req_o) begin
                if (wait_cnt == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_data_i  = mem_word(rd_addr_o);
                    wait_cnt    = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end
            #2;
            if (monitor_on) begin
                if (rf_we_o) begin
                    if (wr_ptr >= exp_n) begin
                        chk(0, "R8 extra write", 32'(wr_ptr), 32'(exp_n));
                    end else begin
                        chk(rd_addr_o == op_sp + 32'(exp_off[wr_ptr]), op_tag, rd_addr_o, op_sp + 32'(exp_off[wr_ptr]));
                        chk(rf_idx_o == 4'(exp_idx[wr_ptr]), "R2 index", 32'(rf_idx_o), 32'(exp_idx[wr_ptr]));
                        chk(rf_data_o == rsp_data_i, "R7 data", rf_data_o, rsp_data_i);
                    end
                    wr_ptr++;
                end
                if (done_o && !done_seen) begin
                    done_seen = 1;
                    chk(wr_ptr == exp_n, "R6 writes before done", 32'(wr_ptr), 32'(exp_n));
                    chk(sp_wr_en_o == (op_mask != 0), "R6 sp enable", 32'(sp_wr_en_o), 32'(op_mask != 0));
                    if (op_mask != 0)
                        chk(sp_wr_data_o == op_sp + 32'(exp_adv), "R6 new SP", sp_wr_data_o, op_sp + 32'(exp_adv));
                end
            end
        end
    end

    task automatic run_op(input logic [4:0] m, input logic [31:0] sp, input bit inject);
        int n_cyc;
        build_exp(m);
        op_mask = m; op_sp = sp; wr_ptr = 0; done_seen = 0; monitor_on = 1;
        op_tag = m[4] ? (m[3:0] != 0 ? "R5 address" : "R4 address") : "R3 address";
        @(negedge clk);
        start_i = 1'b1; mask_i = m; sp_i = sp;
        n_cyc = 0;
        while (!done_seen && n_cyc < 100) begin
            @(negedge clk);
            if (n_cyc == 0) start_i = 1'b0;
            if (inject && n_cyc == 1) begin
                start_i = 1'b1; mask_i = ~m; sp_i = sp ^ 32'h0000_1000;
            end
            if (inject && n_cyc == 2) start_i = 1'b0;
            #3;
            n_cyc++;
        end
        start_i = 1'b0;
        chk(done_seen, "R6 done reached", 32'(done_seen), 1);
        if (m == 0) chk(n_cyc == 1, "R8 done next cycle", 32'(n_cyc), 1);
        if (inject) chk(wr_ptr == exp_n, "R9 start ignored", 32'(wr_ptr), 32'(exp_n));
        @(negedge clk); #3;
        chk(!done_o && !busy_o, "R10 done single pulse", {30'd0, done_o, busy_o}, 0);
        monitor_on = 0;
    endtask

    initial begin
        int guard = 0;
        forever begin
            @(posedge clk);
            guard++;
            if (guard > 150000) begin
                fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #2;
        chk(!busy_o && !done_o && !rd_req_o && !rf_we_o && !sp_wr_en_o, "R1 reset state",
            {27'd0, busy_o, done_o, rd_req_o, rf_we_o, sp_wr_en_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        // directed corners
        for (int k = 0; k < 4; k++) run_op(5'(1 << k), 32'h0000_2000, 0);
        run_op(5'b01111, 32'h0000_3000, 0);
        run_op(5'b10000, 32'h0000_4000, 0);
        run_op(5'b10001, 32'h0000_4100, 0);
        run_op(5'b11010, 32'h0000_4200, 0);
        run_op(5'b11111, 32'h0000_4300, 0);
        run_op(5'b00000, 32'h0000_5000, 0);
        run_op(5'b00101, 32'h0000_6000, 1);
        run_op(5'b10110, 32'h0000_6100, 1);
        // random
        for (int i = 0; i < 60; i++) begin
            run_op(5'($urandom), $urandom & 32'h7FFF_FF00, (i % 7) == 3);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule